// File: doc/BRIEF.md
# Divider Tap Rate Selector

This block is the prescaler of a real-time clock. A binary countdown chain of fifteen stages advances once for each cycle of the 32.768 kHz oscillator enable. It produces a one-second tick for the calendar logic when the chain wraps. A 3-bit divider-control field sets the chain in one of three states. It can run, it can be held at zero with the oscillator still on, or it can be frozen because the oscillator is off.

A 4-bit rate code picks one chain stage through a single sixteen-way tap multiplexer. That one selected tap feeds two outputs. The square-wave pin gives the tap level when its enable is set and is held low otherwise. The periodic event is a one-cycle pulse on each rising edge of the tap, and it is produced whatever the square-wave enable is. Rate code zero selects nothing. A new rate code is registered and used from the next clock. In the first cycle of a new code no periodic pulse is given, so that a level step in the multiplexer is not taken as an edge.

Every pin is a plain control or status signal. No data stream passes through the block, so it has no handshake.

Top module: `divtap_rate_sel`

## Requirements
- R1: With divider control 3'b010 the chain runs. It advances by one on each clock edge that samples `osc_tick` high and holds its value on the other edges.
- R2: With divider control 3'b110 or 3'b111 the chain is forced to zero. From the following cycle on, `sqw_out`, `periodic_pulse` and `second_tick` are all low.
- R3: Every other divider-control code (000, 001, 011, 100, 101) freezes the chain at its present value, and it resumes from that value when running is selected again.
- R4: Rate code n in 3..15 selects chain bit n-2, which is a square wave of 65536/2^n Hz at a 32.768 kHz tick rate: 8192 Hz down to 2 Hz, so periods run from about 122 us to 500 ms. Code 1 selects bit 6 (256 Hz) and code 2 selects bit 7 (128 Hz).
- R5: Rate code 0 selects no tap. In the cycle after it is sampled, `sqw_out` and `periodic_pulse` are low.
- R6: `sqw_out` equals the selected tap while `sqw_en` is 1 and is 0 while `sqw_en` is 0. The tap follows the rate code sampled at the previous clock edge.
- R7: `periodic_pulse` is high for exactly one cycle, the cycle after the selected tap has gone from 0 to 1, whatever the value of `sqw_en`.
- R8: In the cycle after a rate code that differs from the previous one is sampled, `periodic_pulse` is low.
- R9: `second_tick` is high for one cycle after the chain wraps from all ones to zero, which happens once every 32768 advances.
- R10: While `rst_n` is low the chain and the registered rate code are zero and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-cycle enable at the 32.768 kHz oscillator rate |
| div_ctl | input | 3 | Divider control: run, hold in reset, or oscillator off |
| rate_code | input | 4 | Tap select shared by the square wave and the periodic event |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_out | output | 1 | Square-wave pin value |
| periodic_pulse | output | 1 | One-cycle pulse on each rising edge of the selected tap |
| second_tick | output | 1 | One-cycle pulse when the chain wraps |

## Verification
The hardest case to reach is a rate-code change in the same cycle as a rising edge. This includes a switch from a low tap to a tap that is already high, where a naive design would give a false pulse. Directed bursts change the code every cycle or every few cycles while the chain runs at full rate. A long random phase then mixes code changes with holds, freezes and a gated oscillator enable. A bench model predicts every output in every cycle. The one-second wrap is reached with a full window of 32768 advances, and the bench checks that the window holds exactly one tick.

// File: rtl/divtap_pkg.sv
package divtap_pkg;

  localparam int CHAIN_STAGES = 15;
  localparam int RATE_BITS    = 4;
  localparam int CTL_BITS     = 3;

  // low codes reuse two mid-chain stages; higher codes map linearly
  localparam int ALIAS_ONE_TAP = 6;
  localparam int ALIAS_TWO_TAP = 7;
  localparam int LINEAR_OFFSET = 2;

  typedef enum logic [1:0] {
    CHAIN_OFF  = 2'd0,
    CHAIN_RUN  = 2'd1,
    CHAIN_HOLD = 2'd2
  } chain_mode_e;

  function automatic chain_mode_e decode_ctl(input logic [CTL_BITS-1:0] ctl);
    if (ctl[2:1] == 2'b11)
      return CHAIN_HOLD;
    else if (ctl == 3'b010)
      return CHAIN_RUN;
    else
      return CHAIN_OFF;
  endfunction

  // returns -1 when a code selects no stage
  function automatic int tap_for_code(input int code);
    if (code == 0)
      return -1;
    else if (code == 1)
      return ALIAS_ONE_TAP;
    else if (code == 2)
      return ALIAS_TWO_TAP;
    else
      return code - LINEAR_OFFSET;
  endfunction

endpackage

// File: rtl/divtap_ctl_decode.sv
module divtap_ctl_decode
  import divtap_pkg::*;
(
  input  logic [CTL_BITS-1:0] div_ctl,
  output chain_mode_e         mode
);

  always_comb begin
    mode = decode_ctl(div_ctl);
  end

endmodule

// File: rtl/divtap_chain.sv
module divtap_chain
  import divtap_pkg::*;
#(
  parameter int STAGES = CHAIN_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  chain_mode_e       mode,
  output logic [STAGES-1:0] count,
  output logic              wrap_tick
);

  localparam logic [STAGES-1:0] STEP = STAGES'(1);

  logic advance;

  assign advance = (mode == CHAIN_RUN) && osc_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      wrap_tick <= 1'b0;
    end else begin
      wrap_tick <= advance && (&count);
      unique case (mode)
        CHAIN_HOLD: count <= '0;
        CHAIN_RUN:  if (osc_tick) count <= count + STEP;
        default:    count <= count;
      endcase
    end
  end

endmodule

// File: rtl/divtap_tap_mux.sv
module divtap_tap_mux
  import divtap_pkg::*;
#(
  parameter int STAGES = CHAIN_STAGES,
  parameter int RATE_W = RATE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] count,
  input  logic [RATE_W-1:0] rate_code,
  output logic              tap,
  output logic              code_new
);

  localparam int CODES = 1 << RATE_W;

  logic [RATE_W-1:0] code_q;
  logic [CODES-1:0]  lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      code_new <= 1'b0;
    end else begin
      code_q   <= rate_code;
      code_new <= (rate_code != code_q);
    end
  end

  for (genvar c = 0; c < CODES; c++) begin : g_lane
    localparam int TAP_IDX = tap_for_code(c);
    if (TAP_IDX < 0 || TAP_IDX >= STAGES) begin : g_none
      assign lane[c] = 1'b0;
    end else begin : g_bit
      assign lane[c] = count[TAP_IDX];
    end
  end

  assign tap = lane[code_q];

endmodule

// File: rtl/divtap_edge_gen.sv
module divtap_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tap,
  input  logic code_new,
  input  logic sqw_en,
  output logic sqw_out,
  output logic periodic_pulse
);

  logic tap_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tap_last <= 1'b0;
    else
      tap_last <= tap;
  end

  // a level step from a code change is not an edge
  assign periodic_pulse = tap && !tap_last && !code_new;
  assign sqw_out        = sqw_en && tap;

endmodule

// File: rtl/divtap_rate_sel.sv
module divtap_rate_sel
  import divtap_pkg::*;
#(
  parameter int STAGES = CHAIN_STAGES,
  parameter int RATE_W = RATE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                osc_tick,
  input  logic [CTL_BITS-1:0] div_ctl,
  input  logic [RATE_W-1:0]   rate_code,
  input  logic                sqw_en,
  output logic                sqw_out,
  output logic                periodic_pulse,
  output logic                second_tick
);

  chain_mode_e       mode;
  logic [STAGES-1:0] count;
  logic              tap;
  logic              code_new;

  divtap_ctl_decode u_decode (
    .div_ctl (div_ctl),
    .mode    (mode)
  );

  divtap_chain #(.STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .mode      (mode),
    .count     (count),
    .wrap_tick (second_tick)
  );

  divtap_tap_mux #(.STAGES(STAGES), .RATE_W(RATE_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .rate_code (rate_code),
    .tap       (tap),
    .code_new  (code_new)
  );

  divtap_edge_gen u_edge (
    .clk            (clk),
    .rst_n          (rst_n),
    .tap            (tap),
    .code_new       (code_new),
    .sqw_en         (sqw_en),
    .sqw_out        (sqw_out),
    .periodic_pulse (periodic_pulse)
  );

endmodule

// File: rtl/divtap_rate_sel_chk.sv
module divtap_rate_sel_chk #(
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_tick,
  input logic [2:0]        div_ctl,
  input logic [RATE_W-1:0] rate_code,
  input logic              sqw_en,
  input logic              sqw_out,
  input logic              periodic_pulse,
  input logic              second_tick
);

  logic [RATE_W-1:0] code_seen;
  logic              advanced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_seen <= '0;
      advanced  <= 1'b0;
    end else begin
      code_seen <= rate_code;
      advanced  <= (div_ctl == 3'b010) && osc_tick;
    end
  end

  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl[2:1] == 2'b11) |=> (!second_tick && !periodic_pulse && !sqw_out));

  // R5
  no_tap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |=> (!sqw_out && !periodic_pulse));

  // R6
  sqw_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw_out);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |=> !periodic_pulse);

  // R8
  new_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code != code_seen) |=> !periodic_pulse);

  // R9
  wrap_after_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_tick |-> advanced);

  // R9
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_tick |=> !second_tick);

endmodule

bind divtap_rate_sel divtap_rate_sel_chk #(.RATE_W(RATE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .osc_tick       (osc_tick),
  .div_ctl        (div_ctl),
  .rate_code      (rate_code),
  .sqw_en         (sqw_en),
  .sqw_out        (sqw_out),
  .periodic_pulse (periodic_pulse),
  .second_tick    (second_tick)
);

// File: tb/divtap_rate_sel_test.sv
module divtap_rate_sel_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [2:0] div_ctl = 3'b000;
  logic [3:0] rate_code = 4'd0;
  logic       sqw_en = 1'b0;
  logic       sqw_out, periodic_pulse, second_tick;

  always #4 clk = ~clk;

  divtap_rate_sel uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .osc_tick       (osc_tick),
    .div_ctl        (div_ctl),
    .rate_code      (rate_code),
    .sqw_en         (sqw_en),
    .sqw_out        (sqw_out),
    .periodic_pulse (periodic_pulse),
    .second_tick    (second_tick)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string phase   = "R10";

  // reference state built from the requirements
  logic [14:0] m_cnt;
  logic [3:0]  m_code;
  logic        m_prev, m_chg, m_sec;

  function automatic logic ref_tap(input logic [14:0] c, input logic [3:0] code);
    int idx;
    if (code == 4'd0) return 1'b0;
    if (code == 4'd1) idx = 6;
    else if (code == 4'd2) idx = 7;
    else idx = int'(code) - 2;
    return c[idx];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_code <= '0; m_prev <= 1'b0; m_chg <= 1'b0; m_sec <= 1'b0;
    end else begin
      m_prev <= ref_tap(m_cnt, m_code);
      m_code <= rate_code;
      m_chg  <= (rate_code != m_code);
      m_sec  <= 1'b0;
      if (div_ctl[2:1] == 2'b11)
        m_cnt <= '0;
      else if (div_ctl == 3'b010 && osc_tick) begin
        m_cnt <= m_cnt + 15'd1;
        m_sec <= &m_cnt;
      end
    end
  end

  task automatic check_outputs();
    logic t, e_sqw, e_per;
    t     = ref_tap(m_cnt, m_code);
    e_sqw = sqw_en & t;
    e_per = t & ~m_prev & ~m_chg;
    n_tests++;
    if (sqw_out !== e_sqw || periodic_pulse !== e_per || second_tick !== m_sec) begin
      n_fail++;
      $display("FAIL %s: sqw/per/sec actual %b%b%b expected %b%b%b",
               phase, sqw_out, periodic_pulse, second_tick, e_sqw, e_per, m_sec);
    end
  endtask

  task automatic step(input logic osc, input logic [2:0] dv,
                      input logic [3:0] rc, input logic en);
    @(negedge clk);
    check_outputs();
    osc_tick = osc; div_ctl = dv; rate_code = rc; sqw_en = en;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog (R1): actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int ticks;
    logic [2:0] offc [5] = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101};
    void'($urandom(32'd20240611));

    // R10: reset holds everything low even with live inputs
    phase = "R10";
    osc_tick = 1'b1; div_ctl = 3'b010; rate_code = 4'd3; sqw_en = 1'b1;
    for (int i = 0; i < 5; i++) begin @(negedge clk); check_outputs(); end
    rst_n = 1'b1;

    // R1: full-rate run on the fastest tap
    phase = "R1";
    for (int i = 0; i < 64; i++) step(1'b1, 3'b010, 4'd3, 1'b1);
    for (int i = 0; i < 64; i++) step(i[1], 3'b010, 4'd3, 1'b1);

    // R4: every code, a little over one tap period each
    phase = "R4";
    for (int c = 1; c < 16; c++) begin
      int idx = (c == 1) ? 6 : (c == 2) ? 7 : c - 2;
      for (int i = 0; i < (2 << idx) + 40; i++) step(1'b1, 3'b010, 4'(c), 1'b1);
    end

    // R5: no tap selected
    phase = "R5";
    for (int i = 0; i < 300; i++) step(1'b1, 3'b010, 4'd0, 1'b1);

    // R6: enable toggled at random on a fast tap
    phase = "R6";
    for (int i = 0; i < 400; i++) step(1'b1, 3'b010, 4'd4, 1'($urandom % 2));

    // R7: periodic event with square wave disabled
    phase = "R7";
    for (int i = 0; i < 300; i++) step(1'b1, 3'b010, 4'd3, 1'b0);

    // R8: codes changed every cycle, then every few cycles
    phase = "R8";
    for (int i = 0; i < 300; i++) step(1'b1, 3'b010, 4'(1 + ($urandom % 15)), 1'b1);
    for (int i = 0; i < 600; i++)
      step(1'b1, 3'b010, ((i % 3) == 0) ? 4'(3 + ($urandom % 4)) : rate_code, 1'b1);

    // R2: both hold codes
    phase = "R2";
    for (int i = 0; i < 50; i++) step(1'b1, 3'b110, 4'd3, 1'b1);
    for (int i = 0; i < 50; i++) step(1'b1, 3'b111, 4'd5, 1'b1);
    for (int i = 0; i < 50; i++) step(1'b1, 3'b010, 4'd3, 1'b1);

    // R3: oscillator-off codes freeze the chain
    phase = "R3";
    for (int i = 0; i < 300; i++) step(1'b1, offc[$urandom % 5], 4'd3, 1'b1);
    for (int i = 0; i < 50; i++) step(1'b1, 3'b010, 4'd3, 1'b1);

    // R9: one wrap in any window of 32768 advances
    phase = "R9";
    step(1'b1, 3'b010, 4'd15, 1'b1);
    ticks = 0;
    for (int i = 0; i < 32768; i++) begin
      step(1'b1, 3'b010, 4'd15, 1'b1);
      if (second_tick === 1'b1) ticks++;
    end
    n_tests++;
    if (ticks != 1) begin
      n_fail++;
      $display("FAIL R9: second ticks actual %0d expected 1", ticks);
    end

    // R4: random mix of modes, gated ticks and code changes
    phase = "R4";
    for (int i = 0; i < 15000; i++) begin
      int r = $urandom % 100;
      logic [2:0] dv = (r < 85) ? 3'b010 : (r < 92) ? 3'(6 + ($urandom % 2)) : offc[$urandom % 5];
      logic [3:0] rc = (($urandom % 50) == 0) ? 4'($urandom % 16) : rate_code;
      logic en = (($urandom % 20) == 0) ? ~sqw_en : sqw_en;
      step(1'(($urandom % 10) < 7), dv, rc, en);
    end

    @(negedge clk); check_outputs();
    summary();
    $finish;
  end

endmodule